// File: doc/BRIEF.md
# Fixed-Period Two-Wire Fan PWM Controller

This block drives a single two-wire fan line with a pulse-width modulated signal. The period is fixed, 40 ms at the default clock. Software controls it through a small word-addressed register space on a plain read/write strobe bus. A control word holds a run flag, a mode selector and an 8-bit duty code. A second word holds a 16-bit maximum-speed value that is only stored and read back. At the start of each period the output is high for `floor(duty * PERIOD_CYCLES / 255)` clock cycles and then low for the rest of the period. A duty code of 255 therefore keeps the line permanently high.

The output sequencing is a three-state machine. **OFF** is idle and the line is low. **HIGH** is the active part of the period. **LOW** is the inactive part. The named transitions are:
- *start* (OFF to HIGH, or OFF to LOW when the duty is zero): the run flag is seen set, and the period counter restarts at zero.
- *fall* (HIGH to LOW): the next count reaches the high time.
- *rise* (LOW to HIGH): the counter wraps to a new period.
- *hold*: the state stays the same.
- *stop* (HIGH or LOW to OFF): the run flag is seen clear.

The duty code is applied on the next clock without waiting for a period boundary. The period in which the code changes can therefore mix the old and new high times. Clearing the run flag forces the line low at once. No record of the running period is kept.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset both registers read as zero and `fan_o` is low.
- R2: The control word is at byte offset 0x0. Bit 0 is the run flag, bit 1 is the mode selector and bits 23:16 are the duty code. All other bits read as zero. Read data appears on `rdata_o` in the cycle after the `rd_en_i` cycle.
- R3: The speed word is at byte offset 0x4. Bits 15:0 are stored and read back, and the upper bits read as zero. Writing it has no effect on `fan_o`.
- R4: Offsets other than 0x0 and 0x4 read as zero. Writes to them change no register.
- R5: While running, the output period is exactly PERIOD_CYCLES clocks. The line is high for the first `floor(duty*PERIOD_CYCLES/255)` clocks of each period and low for the rest.
- R6: With duty code 255 the line stays high continuously. With duty code 0 it stays low.
- R7: A write that sets the run flag while it is clear leaves the line low in the next cycle. The period then restarts with cycle 0 of the period one cycle later. Rewriting the flag as 1 while it is already set does not restart the period.
- R8: A write that clears the run flag forces `fan_o` low from the next cycle onward.
- R9: A new duty code is used from the second cycle after its write cycle, without waiting for a period boundary. The period phase is kept.
- R10: The mode selector is stored and read back but does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fan_o | output | 1 | PWM drive to the fan |

## Verification
Some properties are checked on every cycle:
- The period counter never leaves its range.
- The line is low right after any write that clears the run flag.
- The line stays high under a held full-scale code and low under a held zero code.
- Reserved bits and unmapped offsets always read back as zero.

Other properties need the bench's scenarios:
- The exact high-time count, and its rounding at full scale.
- Where the period restarts after the run flag is set.
- The blended period when the duty changes in the middle of a period.
- That the mode bit and speed word leave the waveform unchanged.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    localparam int REG_W     = 32;
    localparam int DUTY_W    = 8;
    localparam int DUTY_FULL = 255;
    localparam int SPEED_W   = 16;

    // control word field positions
    localparam int RUN_POS   = 0;
    localparam int MODE_POS  = 1;
    localparam int DUTY_LSB  = 16;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } pwm_phase_e;

    typedef struct packed {
        logic              run;
        logic              mode;
        logic [DUTY_W-1:0] duty;
    } ctrl_t;

endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    output ctrl_t               ctrl_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   word_idx;
    logic               hit_ctrl;
    logic               hit_speed;
    logic [SPEED_W-1:0] speed_q;
    logic [REG_W-1:0]   rd_mux;
    logic               unused_bits;

    assign word_idx  = addr_i[ADDR_W-1:2];
    assign hit_ctrl  = (word_idx == IDX_W'(0));
    assign hit_speed = (word_idx == IDX_W'(1));
    assign unused_bits = ^{addr_i[1:0], wdata_i[REG_W-1:DUTY_LSB+DUTY_W],
                           wdata_i[DUTY_LSB-1:MODE_POS+1]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_o  <= '0;
            speed_q <= '0;
        end else if (wr_en_i) begin
            if (hit_ctrl) begin
                ctrl_o.run  <= wdata_i[RUN_POS];
                ctrl_o.mode <= wdata_i[MODE_POS];
                ctrl_o.duty <= wdata_i[DUTY_LSB +: DUTY_W];
            end
            if (hit_speed) begin
                speed_q <= wdata_i[SPEED_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[RUN_POS]             = ctrl_o.run;
            rd_mux[MODE_POS]            = ctrl_o.mode;
            rd_mux[DUTY_LSB +: DUTY_W]  = ctrl_o.duty;
        end else if (hit_speed) begin
            rd_mux[SPEED_W-1:0]         = speed_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/fan_pwm_scale.sv
module fan_pwm_scale
    import fan_pwm_pkg::*;
#(
    parameter int PERIOD_CYCLES = 510,
    parameter int CNT_W         = $clog2(PERIOD_CYCLES + 1)
) (
    input  logic [DUTY_W-1:0] duty_i,
    output logic [CNT_W-1:0]  high_cnt_o
);

    localparam int PROD_W = CNT_W + DUTY_W;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] quotient;
    logic              unused_hi;

    always_comb begin
        product    = PROD_W'(duty_i) * PROD_W'(PERIOD_CYCLES);
        quotient   = product / PROD_W'(DUTY_FULL);
        high_cnt_o = quotient[CNT_W-1:0];
    end

    assign unused_hi = ^quotient[PROD_W-1:CNT_W];

endmodule

// File: rtl/fan_pwm_fsm.sv
module fan_pwm_fsm
    import fan_pwm_pkg::*;
#(
    parameter int PERIOD_CYCLES = 510,
    parameter int CNT_W         = $clog2(PERIOD_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fan_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

    pwm_phase_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_step;

    assign cnt_step = (cnt_o == LAST) ? '0 : cnt_o + CNT_W'(1);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PH_OFF;
            cnt_o   <= '0;
        end else begin
            state_q <= state_d;
            cnt_o   <= cnt_d;
        end
    end

    // transitions: start, fall, rise, hold, stop
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_o;
        unique case (state_q)
            PH_OFF: begin
                if (run_i) begin
                    cnt_d   = '0;
                    state_d = (high_cnt_i != '0) ? PH_HIGH : PH_LOW;
                end
            end
            PH_HIGH, PH_LOW: begin
                if (!run_i) begin
                    cnt_d   = '0;
                    state_d = PH_OFF;
                end else begin
                    cnt_d   = cnt_step;
                    state_d = (cnt_step < high_cnt_i) ? PH_HIGH : PH_LOW;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = PH_OFF;
            end
        endcase
    end

    // outputs: clearing the run flag silences the line without waiting
    always_comb begin
        fan_o = (state_q == PH_HIGH) && run_i;
    end

endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ        = 125_000_000,
    parameter int PERIOD_CYCLES = CLK_HZ / 25,
    parameter int ADDR_W        = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              fan_o
);

    localparam int CNT_W = $clog2(PERIOD_CYCLES + 1);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] per_cnt;

    fan_pwm_regs #(
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .ctrl_o  (ctrl_q)
    );

    fan_pwm_scale #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .CNT_W         (CNT_W)
    ) i_scale (
        .duty_i     (ctrl_q.duty),
        .high_cnt_o (high_cnt)
    );

    fan_pwm_fsm #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .CNT_W         (CNT_W)
    ) i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (ctrl_q.run),
        .high_cnt_i (high_cnt),
        .cnt_o      (per_cnt),
        .fan_o      (fan_o)
    );

endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
    parameter int ADDR_W        = 4,
    parameter int PERIOD_CYCLES = 510,
    parameter int CNT_W         = $clog2(PERIOD_CYCLES + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wdata_i,
    input logic [31:0]       rdata_i,
    input logic              fan_i,
    input logic              run_i,
    input logic [7:0]        duty_i,
    input logic [CNT_W-1:0]  cnt_i
);

    localparam int IDX_W = ADDR_W - 2;

    assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i < CNT_W'(PERIOD_CYCLES));

    assert_stop_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && (addr_i[ADDR_W-1:2] == IDX_W'(0)) && !wdata_i[0]) |-> !fan_i);

    assert_full_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && duty_i == 8'hFF && $past(duty_i) == 8'hFF) |-> fan_i);

    assert_zero_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_i == 8'h00 && $past(duty_i) == 8'h00) |-> !fan_i);

    assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_en_i) |-> rdata_i[31:24] == 8'h00);

    assert_hole_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_en_i && (addr_i[ADDR_W-1:2] > IDX_W'(1))) |-> rdata_i == 32'h0);

endmodule

bind fan_pwm_ctrl fan_pwm_chk #(
    .ADDR_W        (ADDR_W),
    .PERIOD_CYCLES (PERIOD_CYCLES),
    .CNT_W         (CNT_W)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_i (rdata_o),
    .fan_i   (fan_o),
    .run_i   (ctrl_q.run),
    .duty_i  (ctrl_q.duty),
    .cnt_i   (per_cnt)
);

// File: tb/test_fan_pwm_ctrl.sv
module test_fan_pwm_ctrl;

    localparam int PER = 510;
    localparam int AW  = 4;

    typedef struct {
        int          cyc;
        bit          is_read;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          fan;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fan_pwm_ctrl #(.PERIOD_CYCLES(PER), .ADDR_W(AW)) i_fan_pwm_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fan_o(fan)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    // monitor: compare due items as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc == cyc) begin
                    check(sb_q[i].req, sb_q[i].is_read ? rdata : {31'b0, fan}, sb_q[i].exp);
                    sb_q.delete(i);
                end
            end
        end
    end

    task automatic push(int c, bit is_rd, logic [31:0] e, string req);
        item_t it;
        it.cyc = c; it.is_read = is_rd; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    // expected line level from cycle a to b: phase (t - t0) mod PER below h
    task automatic push_fan(int a, int b, int t0, int h, string req);
        for (int t = a; t <= b; t++) begin
            push(t, 1'b0, {31'b0, (((t - t0) % PER) < h)}, req);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string req);
        push(cyc + 1, 1'b1, e, req);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle_run(int n, int t0, int h, string req);
        if (n > 0) begin
            push_fan(cyc + 1, cyc + n, t0, h, req);
            repeat (n) @(negedge clk);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        int c;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", {31'b0, fan}, 32'h0);
        rd(4'h0, 32'h0, "R1");
        rd(4'h4, 32'h0, "R1");

        // R2 field layout, reserved bits read zero
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, 32'h00FF_0002, "R2");
        check("R2", {31'b0, fan}, 32'h0);

        // R4 unmapped offsets
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h8, 32'h0, "R4");
        rd(4'hC, 32'h0, "R4");
        rd(4'h0, 32'h00FF_0002, "R4");

        // R3 speed word
        wr(4'h4, 32'hABCD_1234);
        rd(4'h4, 32'h0000_1234, "R3");
        rd(4'h0, 32'h00FF_0002, "R4");
        wr(4'h0, 32'h0);

        // R5/R7 start with duty 128 -> high 256 of 510
        c = cyc; t0 = c + 2;
        push_fan(c + 1, c + 1, 0, 0, "R7");
        push_fan(c + 2, c + 1 + 2 * PER, t0, 256, "R5");
        wr(4'h0, 32'h0080_0001);
        repeat (2 * PER) @(negedge clk);

        // R3 speed write while running leaves waveform alone
        c = cyc;
        push_fan(c + 1, c + PER, t0, 256, "R3");
        wr(4'h4, 32'h0000_FFFF);
        repeat (PER - 1) @(negedge clk);

        // R9 duty change mid-period at phase 150 (old high, new low)
        idle_run((150 - ((cyc - t0) % PER) + PER) % PER, t0, 256, "R9");
        c = cyc;
        push_fan(c + 1, c + 1, t0, 256, "R9");
        push_fan(c + 2, c + 1 + 2 * PER, t0, 102, "R9");
        wr(4'h0, 32'h0033_0001);
        repeat (2 * PER) @(negedge clk);

        // R10 mode bit, R7 rewrite of run=1 keeps phase
        c = cyc;
        push_fan(c + 1, c + PER, t0, 102, "R10");
        wr(4'h0, 32'h0033_0003);
        repeat (PER - 1) @(negedge clk);

        // R8 stop during high time
        idle_run((50 - ((cyc - t0) % PER) + PER) % PER, t0, 102, "R8");
        c = cyc;
        push_fan(c + 1, c + 40, 0, 0, "R8");
        wr(4'h0, 32'h0033_0002);
        repeat (39) @(negedge clk);
        rd(4'h4, 32'h0000_FFFF, "R3");
        rd(4'h0, 32'h0033_0002, "R10");

        // R7 restart from cycle 0
        c = cyc; t0 = c + 2;
        push_fan(c + 1, c + 1, 0, 0, "R7");
        push_fan(c + 2, c + 1 + PER, t0, 256, "R7");
        wr(4'h0, 32'h0080_0001);
        repeat (PER) @(negedge clk);

        // R6 full scale
        c = cyc;
        push_fan(c + 1, c + 1, 0, 0, "R8");
        wr(4'h0, 32'h0);
        c = cyc; t0 = c + 2;
        push_fan(c + 1, c + 1, 0, 0, "R7");
        push_fan(c + 2, c + 1 + 2 * PER, t0, PER, "R6");
        wr(4'h0, 32'h00FF_0001);
        repeat (2 * PER) @(negedge clk);

        // R6 zero duty
        c = cyc;
        push_fan(c + 1, c + 1, 0, 0, "R8");
        wr(4'h0, 32'h0);
        c = cyc;
        push_fan(c + 1, c + PER + 5, 0, 0, "R6");
        wr(4'h0, 32'h0000_0001);
        repeat (PER + 4) @(negedge clk);

        // R5 smallest nonzero duty -> high 2 cycles
        c = cyc;
        push_fan(c + 1, c + 1, 0, 0, "R8");
        wr(4'h0, 32'h0);
        c = cyc; t0 = c + 2;
        push_fan(c + 1, c + 1, 0, 0, "R7");
        push_fan(c + 2, c + 1 + 2 * PER, t0, 2, "R5");
        wr(4'h0, 32'h0001_0001);
        repeat (2 * PER) @(negedge clk);

        repeat (2) @(negedge clk);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R5: pending items actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        report();
    end

endmodule